// File: doc/BRIEF.md
# Coherent Line Push Master Engine

This block holds a bank of write-back master machines that take a modified line out of an accelerator's coherence directory and send it toward memory. A command names one machine by index and a directory slot. That machine then works through a fixed sequence:

1. It asks the snoop pipeline for a directory lookup, which returns the line address.
2. It protects that address against other snoopers.
3. It issues a push command on the bus.
4. On the combined response, it forwards the destination routing to the bridge sideband.
5. It invalidates the directory entry.
6. It posts a completion message so the accelerator can update its own copy and push the data.

Several machines can be in flight at once. Each one owns a different line. They share the lookup port, the bus command port, the directory write port and the message port. On each of these ports the lowest-numbered requesting machine wins. Moving the line data is left to the bridge and the accelerator.

Top module: `line_push_engine`

## Requirements
- R1: A command on `cmd_valid` whose `cmd_idx` names an idle machine starts that machine. In the next cycle it raises `pipe_req` with `pipe_id` = index and `pipe_slot` = the commanded slot. No bus command is issued before the lookup result arrives.
- R2: A lookup response with `dir_rsp_hit`=1 for the machine makes it drive `bus_cmd_valid` in the next cycle, with `bus_cmd_id` = index and `bus_cmd_addr` = the address from the response.
- R3: From the lookup hit until its directory write is granted, the machine holds its line protected. During that time `snp_retry` rises in the same cycle for any `snp_valid` whose `snp_addr` equals the line address. It stays low for other addresses and at all other times.
- R4: A combined response with `cresp_retry`=1 makes the machine withdraw its bus command for exactly 4 cycles. It then reissues the same command.
- R5: A combined response with `cresp_retry`=0 for a machine that is waiting drives `sb_valid` one cycle later, with `sb_id` = index and `sb_route` = `cresp_route`. A combined response for a machine that is not waiting produces no sideband output.
- R6: In the cycle after a good combined response, the machine raises `dwr_req` with `dwr_slot` = its slot. This invalidates the entry.
- R7: After the directory write is granted, the machine raises `msg_valid` with `msg_status`=0 (done), its id, slot and address. It keeps it raised until `msg_ready`, then becomes idle.
- R8: A lookup response with `dir_rsp_hit`=0 sends the machine straight to the message step with `msg_status`=1 (miss). It issues no bus command.
- R9: A command that names a busy machine is ignored. It changes neither that machine's slot nor its progress.
- R10: On each shared port the lowest-numbered requesting machine is presented. A machine that is not granted keeps requesting.
- R11: During reset all request and valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Push command present |
| cmd_idx | input | IDX_W | Target machine index |
| cmd_slot | input | SLOT_W | Directory slot of the line to evict |
| pipe_req | output | 1 | Request for a snoop pipeline lookup |
| pipe_id | output | IDX_W | Machine presenting the lookup |
| pipe_slot | output | SLOT_W | Slot to look up |
| pipe_gnt | input | 1 | Pipeline accepts the presented lookup |
| dir_rsp_valid | input | 1 | Lookup result present |
| dir_rsp_id | input | IDX_W | Machine the result belongs to |
| dir_rsp_hit | input | 1 | Entry held modified |
| dir_rsp_addr | input | ADDR_W | Line address from the entry |
| snp_valid | input | 1 | Snoop under check |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_retry | output | 1 | Force retry partial response |
| bus_cmd_valid | output | 1 | Push command on the bus |
| bus_cmd_id | output | IDX_W | Issuing machine |
| bus_cmd_addr | output | ADDR_W | Line address of the push |
| bus_cmd_ready | input | 1 | Bus takes the command |
| cresp_valid | input | 1 | Combined response present |
| cresp_id | input | IDX_W | Machine the response belongs to |
| cresp_retry | input | 1 | Response asks for a retry |
| cresp_route | input | ROUTE_W | Destination routing field |
| sb_valid | output | 1 | Routing to the bridge valid |
| sb_id | output | IDX_W | Machine the routing belongs to |
| sb_route | output | ROUTE_W | Destination routing |
| dwr_req | output | 1 | Directory invalidate request |
| dwr_slot | output | SLOT_W | Slot to invalidate |
| dwr_gnt | input | 1 | Directory write accepted |
| msg_valid | output | 1 | Completion message present |
| msg_id | output | IDX_W | Reporting machine |
| msg_slot | output | SLOT_W | Slot of the evicted line |
| msg_addr | output | ADDR_W | Line address |
| msg_status | output | 1 | 0 done, 1 lookup miss |
| msg_ready | input | 1 | Message taken |

## Verification
The assertions check the following on every cycle:
- Each shared-port grant is one-hot and lies within the requests.
- A protected line keeps the same address throughout its protection.
- A machine never drives the bus after a miss, or in the cycle after a retry response.
- Sideband output only follows a good combined response.
- A pending message is not dropped.

The bench scenarios cover the rest:
- the exact four-cycle backoff;
- the routing value and addresses reaching the ports;
- the address match and miss of the snoop retry;
- priority order between two machines with pending messages;
- ignored commands to busy machines;
- stray combined responses.

// File: rtl/lpm_pkg.sv
// Shared types for the line push engine: machine states and message status codes.
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_LWAIT,
        ST_BUS,
        ST_CRESP,
        ST_BACKOFF,
        ST_DWR,
        ST_MSG
    } mstate_e;

    localparam logic STAT_DONE = 1'b0;
    localparam logic STAT_MISS = 1'b1;
endpackage

// File: rtl/lpm_prio_arb.sv
// Fixed-priority arbiter: the lowest set request bit wins.
// Assumes requests are level signals held until granted; purely combinational.
module lpm_prio_arb #(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic [IW-1:0] win,
    output logic         any
);
    // Scan from the top so the lowest requester is written last.
    always_comb begin
        win = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) win = IW'(k);
        end
    end

    // Any request present and the one-hot grant of the winner.
    always_comb begin
        any = |req;
        gnt = '0;
        if (any) gnt[win] = 1'b1;
    end

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_grant_in_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/lpm_machine.sv
// One push machine: lookup, protect, bus push with retry backoff,
// directory invalidate, completion message.
// Assumes the *_win inputs are already qualified with the shared-port accept.
module lpm_machine
    import lpm_pkg::*;
#(
    parameter int SLOT_W  = 10,
    parameter int ADDR_W  = 40,
    parameter int BACKOFF = 4,
    localparam int BO_W   = $clog2(BACKOFF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SLOT_W-1:0] start_slot,
    input  logic              pipe_win,
    input  logic              rsp_me,
    input  logic              rsp_hit,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic              bus_win,
    input  logic              cresp_me,
    input  logic              cresp_retry,
    input  logic              dwr_win,
    input  logic              msg_win,
    output logic              idle,
    output logic              pipe_req,
    output logic              bus_req,
    output logic              cresp_wait,
    output logic              dwr_req,
    output logic              msg_req,
    output logic              protect,
    output logic [SLOT_W-1:0] slot_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              miss_q
);
    mstate_e          state_q;
    logic [BO_W-1:0]  bo_q;

    // Sequence through the push steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bo_q    <= '0;
            slot_q  <= '0;
            addr_q  <= '0;
            miss_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_LOOKUP;
                    slot_q  <= start_slot;
                    miss_q  <= 1'b0;
                end
                ST_LOOKUP: if (pipe_win) state_q <= ST_LWAIT;
                ST_LWAIT: if (rsp_me) begin
                    addr_q <= rsp_addr;
                    if (rsp_hit) begin
                        state_q <= ST_BUS;
                    end else begin
                        miss_q  <= 1'b1;
                        state_q <= ST_MSG;
                    end
                end
                ST_BUS: if (bus_win) state_q <= ST_CRESP;
                ST_CRESP: if (cresp_me) begin
                    if (cresp_retry) begin
                        state_q <= ST_BACKOFF;
                        bo_q    <= '0;
                    end else begin
                        state_q <= ST_DWR;
                    end
                end
                ST_BACKOFF: begin
                    if (bo_q == BO_W'(BACKOFF - 1)) state_q <= ST_BUS;
                    bo_q <= bo_q + 1'b1;
                end
                ST_DWR: if (dwr_win) state_q <= ST_MSG;
                ST_MSG: if (msg_win) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the state into port requests.
    always_comb begin
        idle       = (state_q == ST_IDLE);
        pipe_req   = (state_q == ST_LOOKUP);
        bus_req    = (state_q == ST_BUS);
        cresp_wait = (state_q == ST_CRESP);
        dwr_req    = (state_q == ST_DWR);
        msg_req    = (state_q == ST_MSG);
        protect    = (state_q == ST_BUS) || (state_q == ST_CRESP) ||
                     (state_q == ST_BACKOFF) || (state_q == ST_DWR);
    end

    assert_protect_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (protect && $past(protect)) |-> $stable(addr_q));
    assert_retry_withdraws_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cresp_wait && cresp_me && cresp_retry) |=> !bus_req);
    assert_miss_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> !bus_req);
endmodule

// File: rtl/line_push_engine.sv
// Bank of push machines sharing lookup, bus, directory write and message ports.
// Assumes responses carry the machine index and commands arrive at most one per cycle.
module line_push_engine
    import lpm_pkg::*;
#(
    parameter int N_MACH  = 32,
    parameter int SLOT_W  = 10,
    parameter int ADDR_W  = 40,
    parameter int ROUTE_W = 8,
    parameter int BACKOFF = 4,
    localparam int IDX_W  = (N_MACH > 1) ? $clog2(N_MACH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [SLOT_W-1:0]  cmd_slot,
    output logic               pipe_req,
    output logic [IDX_W-1:0]   pipe_id,
    output logic [SLOT_W-1:0]  pipe_slot,
    input  logic               pipe_gnt,
    input  logic               dir_rsp_valid,
    input  logic [IDX_W-1:0]   dir_rsp_id,
    input  logic               dir_rsp_hit,
    input  logic [ADDR_W-1:0]  dir_rsp_addr,
    input  logic               snp_valid,
    input  logic [ADDR_W-1:0]  snp_addr,
    output logic               snp_retry,
    output logic               bus_cmd_valid,
    output logic [IDX_W-1:0]   bus_cmd_id,
    output logic [ADDR_W-1:0]  bus_cmd_addr,
    input  logic               bus_cmd_ready,
    input  logic               cresp_valid,
    input  logic [IDX_W-1:0]   cresp_id,
    input  logic               cresp_retry,
    input  logic [ROUTE_W-1:0] cresp_route,
    output logic               sb_valid,
    output logic [IDX_W-1:0]   sb_id,
    output logic [ROUTE_W-1:0] sb_route,
    output logic               dwr_req,
    output logic [SLOT_W-1:0]  dwr_slot,
    input  logic               dwr_gnt,
    output logic               msg_valid,
    output logic [IDX_W-1:0]   msg_id,
    output logic [SLOT_W-1:0]  msg_slot,
    output logic [ADDR_W-1:0]  msg_addr,
    output logic               msg_status,
    input  logic               msg_ready
);
    logic [N_MACH-1:0] m_idle, m_pipe, m_bus, m_cwait, m_dwr, m_msg, m_prot, m_miss;
    logic [N_MACH-1:0] g_pipe, g_bus, g_dwr, g_msg;
    logic [N_MACH-1:0] start_v, rsp_v, cresp_v, snp_hit_v;
    logic [SLOT_W-1:0] m_slot [N_MACH];
    logic [ADDR_W-1:0] m_addr [N_MACH];
    logic [IDX_W-1:0]  w_pipe, w_bus, w_dwr, w_msg;
    logic              a_pipe, a_bus, a_dwr, a_msg;
    logic              cresp_ok;

    // One machine per index, plus its steering and snoop compare.
    for (genvar i = 0; i < N_MACH; i++) begin : g_mach
        // Per-machine decode of commands, responses and snoop matches.
        always_comb begin
            start_v[i]   = cmd_valid && (cmd_idx == IDX_W'(i)) && m_idle[i];
            rsp_v[i]     = dir_rsp_valid && (dir_rsp_id == IDX_W'(i));
            cresp_v[i]   = cresp_valid && (cresp_id == IDX_W'(i));
            snp_hit_v[i] = m_prot[i] && (m_addr[i] == snp_addr);
        end

        lpm_machine #(
            .SLOT_W (SLOT_W),
            .ADDR_W (ADDR_W),
            .BACKOFF(BACKOFF)
        ) u_mach (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start_v[i]),
            .start_slot (cmd_slot),
            .pipe_win   (g_pipe[i] && pipe_gnt),
            .rsp_me     (rsp_v[i]),
            .rsp_hit    (dir_rsp_hit),
            .rsp_addr   (dir_rsp_addr),
            .bus_win    (g_bus[i] && bus_cmd_ready),
            .cresp_me   (cresp_v[i]),
            .cresp_retry(cresp_retry),
            .dwr_win    (g_dwr[i] && dwr_gnt),
            .msg_win    (g_msg[i] && msg_ready),
            .idle       (m_idle[i]),
            .pipe_req   (m_pipe[i]),
            .bus_req    (m_bus[i]),
            .cresp_wait (m_cwait[i]),
            .dwr_req    (m_dwr[i]),
            .msg_req    (m_msg[i]),
            .protect    (m_prot[i]),
            .slot_q     (m_slot[i]),
            .addr_q     (m_addr[i]),
            .miss_q     (m_miss[i])
        );
    end

    lpm_prio_arb #(.N(N_MACH)) u_arb_pipe (
        .clk(clk), .rst_n(rst_n), .req(m_pipe), .gnt(g_pipe), .win(w_pipe), .any(a_pipe));
    lpm_prio_arb #(.N(N_MACH)) u_arb_bus (
        .clk(clk), .rst_n(rst_n), .req(m_bus), .gnt(g_bus), .win(w_bus), .any(a_bus));
    lpm_prio_arb #(.N(N_MACH)) u_arb_dwr (
        .clk(clk), .rst_n(rst_n), .req(m_dwr), .gnt(g_dwr), .win(w_dwr), .any(a_dwr));
    lpm_prio_arb #(.N(N_MACH)) u_arb_msg (
        .clk(clk), .rst_n(rst_n), .req(m_msg), .gnt(g_msg), .win(w_msg), .any(a_msg));

    // Present each port's winner on the shared outputs.
    always_comb begin
        pipe_req      = a_pipe;
        pipe_id       = w_pipe;
        pipe_slot     = m_slot[w_pipe];
        bus_cmd_valid = a_bus;
        bus_cmd_id    = w_bus;
        bus_cmd_addr  = m_addr[w_bus];
        dwr_req       = a_dwr;
        dwr_slot      = m_slot[w_dwr];
        msg_valid     = a_msg;
        msg_id        = w_msg;
        msg_slot      = m_slot[w_msg];
        msg_addr      = m_addr[w_msg];
        msg_status    = m_miss[w_msg] ? STAT_MISS : STAT_DONE;
        snp_retry     = snp_valid && (|snp_hit_v);
        cresp_ok      = !cresp_retry && (|(cresp_v & m_cwait));
    end

    // Register routing from a good combined response onto the bridge sideband.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_valid <= 1'b0;
            sb_id    <= '0;
            sb_route <= '0;
        end else begin
            sb_valid <= cresp_ok;
            if (cresp_ok) begin
                sb_id    <= cresp_id;
                sb_route <= cresp_route;
            end
        end
    end

    assert_sideband_after_good_cresp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sb_valid |-> $past(cresp_valid && !cresp_retry));
    assert_msg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid);
endmodule

// File: tb/line_push_engine_bench.sv
module line_push_engine_bench;
    localparam int N = 32, IW = 5, SW = 10, AW = 40, RW = 8;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [SW-1:0] slot;
        logic          hit;
        logic [AW-1:0] addr;
        logic [1:0]    nretry;
        logic [RW-1:0] route;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'd0,  10'd17,   1'b1, 40'h12_3456_7880, 2'd0, 8'h21},
        '{5'd31, 10'd1023, 1'b1, 40'hFF_FFFF_FF80, 2'd1, 8'h5A},
        '{5'd7,  10'd0,    1'b0, 40'h00_0000_0000, 2'd0, 8'h00},
        '{5'd12, 10'd300,  1'b1, 40'h00_0000_0080, 2'd2, 8'hC3},
        '{5'd19, 10'd512,  1'b0, 40'h00_0000_00AB, 2'd0, 8'h00},
        '{5'd3,  10'd44,   1'b1, 40'h55_AA55_AA00, 2'd3, 8'hE7}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0; logic [IW-1:0] cmd_idx = '0; logic [SW-1:0] cmd_slot = '0;
    logic pipe_req; logic [IW-1:0] pipe_id; logic [SW-1:0] pipe_slot; logic pipe_gnt = 1;
    logic dir_rsp_valid = 0; logic [IW-1:0] dir_rsp_id = '0; logic dir_rsp_hit = 0;
    logic [AW-1:0] dir_rsp_addr = '0;
    logic snp_valid = 0; logic [AW-1:0] snp_addr = '0; logic snp_retry;
    logic bus_cmd_valid; logic [IW-1:0] bus_cmd_id; logic [AW-1:0] bus_cmd_addr;
    logic bus_cmd_ready = 1;
    logic cresp_valid = 0; logic [IW-1:0] cresp_id = '0; logic cresp_retry = 0;
    logic [RW-1:0] cresp_route = '0;
    logic sb_valid; logic [IW-1:0] sb_id; logic [RW-1:0] sb_route;
    logic dwr_req; logic [SW-1:0] dwr_slot; logic dwr_gnt = 1;
    logic msg_valid; logic [IW-1:0] msg_id; logic [SW-1:0] msg_slot; logic [AW-1:0] msg_addr;
    logic msg_status; logic msg_ready = 1;

    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    line_push_engine u_line_push_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_slot(cmd_slot),
        .pipe_req(pipe_req), .pipe_id(pipe_id), .pipe_slot(pipe_slot), .pipe_gnt(pipe_gnt),
        .dir_rsp_valid(dir_rsp_valid), .dir_rsp_id(dir_rsp_id), .dir_rsp_hit(dir_rsp_hit),
        .dir_rsp_addr(dir_rsp_addr),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_retry(snp_retry),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd_id(bus_cmd_id), .bus_cmd_addr(bus_cmd_addr),
        .bus_cmd_ready(bus_cmd_ready),
        .cresp_valid(cresp_valid), .cresp_id(cresp_id), .cresp_retry(cresp_retry),
        .cresp_route(cresp_route),
        .sb_valid(sb_valid), .sb_id(sb_id), .sb_route(sb_route),
        .dwr_req(dwr_req), .dwr_slot(dwr_slot), .dwr_gnt(dwr_gnt),
        .msg_valid(msg_valid), .msg_id(msg_id), .msg_slot(msg_slot), .msg_addr(msg_addr),
        .msg_status(msg_status), .msg_ready(msg_ready)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Probe the snoop retry for one address in the current cycle.
    task automatic snoop(input string req, input logic [AW-1:0] a, input logic exp);
        snp_valid = 1'b1; snp_addr = a; #1;
        chk(req, 64'(snp_retry), 64'(exp));
        snp_valid = 1'b0; #1;
    endtask

    task automatic run_push(input vec_t v);
        @(negedge clk); cmd_valid = 1; cmd_idx = v.idx; cmd_slot = v.slot;
        @(negedge clk); cmd_valid = 0;
        chk("R1 pipe_req", 64'(pipe_req), 64'd1);
        chk("R1 pipe_id", 64'(pipe_id), 64'(v.idx));
        chk("R1 pipe_slot", 64'(pipe_slot), 64'(v.slot));
        chk("R1 no bus before lookup", 64'(bus_cmd_valid), 64'd0);
        @(negedge clk);
        dir_rsp_valid = 1; dir_rsp_id = v.idx; dir_rsp_hit = v.hit; dir_rsp_addr = v.addr;
        @(negedge clk); dir_rsp_valid = 0;
        if (!v.hit) begin
            chk("R8 miss message", 64'(msg_valid), 64'd1);
            chk("R8 miss status", 64'(msg_status), 64'd1);
            chk("R8 miss id", 64'(msg_id), 64'(v.idx));
            chk("R8 no bus", 64'(bus_cmd_valid), 64'd0);
            @(negedge clk);
            chk("R7 idle after message", 64'(msg_valid), 64'd0);
            return;
        end
        chk("R2 bus valid", 64'(bus_cmd_valid), 64'd1);
        chk("R2 bus addr", 64'(bus_cmd_addr), 64'(v.addr));
        chk("R2 bus id", 64'(bus_cmd_id), 64'(v.idx));
        snoop("R3 retry on match", v.addr, 1'b1);
        snoop("R3 no retry other addr", v.addr ^ 40'h80, 1'b0);
        for (int r = 0; r < int'(v.nretry); r++) begin
            @(negedge clk); cresp_valid = 1; cresp_id = v.idx; cresp_retry = 1;
            @(negedge clk); cresp_valid = 0; cresp_retry = 0;
            chk("R4 backoff quiet", 64'(bus_cmd_valid), 64'd0);
            chk("R5 no sideband on retry", 64'(sb_valid), 64'd0);
            snoop("R3 protected in backoff", v.addr, 1'b1);
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                chk("R4 backoff quiet", 64'(bus_cmd_valid), 64'd0);
            end
            @(negedge clk);
            chk("R4 reissue after 4", 64'(bus_cmd_valid), 64'd1);
            chk("R4 reissue addr", 64'(bus_cmd_addr), 64'(v.addr));
        end
        @(negedge clk); cresp_valid = 1; cresp_id = v.idx; cresp_retry = 0; cresp_route = v.route;
        @(negedge clk); cresp_valid = 0;
        chk("R5 sb_valid", 64'(sb_valid), 64'd1);
        chk("R5 sb_id", 64'(sb_id), 64'(v.idx));
        chk("R5 sb_route", 64'(sb_route), 64'(v.route));
        chk("R6 dwr_req", 64'(dwr_req), 64'd1);
        chk("R6 dwr_slot", 64'(dwr_slot), 64'(v.slot));
        snoop("R3 protected until write", v.addr, 1'b1);
        @(negedge clk);
        chk("R7 msg_valid", 64'(msg_valid), 64'd1);
        chk("R7 msg_status", 64'(msg_status), 64'd0);
        chk("R7 msg_addr", 64'(msg_addr), 64'(v.addr));
        chk("R7 msg_slot", 64'(msg_slot), 64'(v.slot));
        chk("R7 msg_id", 64'(msg_id), 64'(v.idx));
        chk("R5 sideband one cycle", 64'(sb_valid), 64'd0);
        snoop("R3 released after write", v.addr, 1'b0);
        @(negedge clk);
        chk("R7 idle after message", 64'(msg_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 pipe_req in reset", 64'(pipe_req), 64'd0);
        chk("R11 bus in reset", 64'(bus_cmd_valid), 64'd0);
        chk("R11 dwr in reset", 64'(dwr_req), 64'd0);
        chk("R11 msg in reset", 64'(msg_valid), 64'd0);
        chk("R11 sb in reset", 64'(sb_valid), 64'd0);
        chk("R11 snp_retry in reset", 64'(snp_retry), 64'd0);
        rst_n = 1;

        for (int k = 0; k < 6; k++) run_push(VECS[k]);

        // R5: combined response for an idle machine gives no sideband.
        @(negedge clk); cresp_valid = 1; cresp_id = 5'd9; cresp_retry = 0; cresp_route = 8'hFF;
        @(negedge clk); cresp_valid = 0;
        chk("R5 stray cresp ignored", 64'(sb_valid), 64'd0);

        // R10: lookup not granted keeps requesting.
        pipe_gnt = 0;
        @(negedge clk); cmd_valid = 1; cmd_idx = 5'd4; cmd_slot = 10'd88;
        @(negedge clk); cmd_valid = 0;
        repeat (3) @(negedge clk);
        chk("R10 held pipe_req", 64'(pipe_req), 64'd1);
        chk("R10 held pipe_id", 64'(pipe_id), 64'd4);
        pipe_gnt = 1;
        @(negedge clk); dir_rsp_valid = 1; dir_rsp_id = 5'd4; dir_rsp_hit = 0;
        @(negedge clk); dir_rsp_valid = 0;
        chk("R8 miss after held lookup", 64'(msg_status), 64'd1);
        @(negedge clk);

        // R10 priority and R9 busy command ignored.
        msg_ready = 0;
        @(negedge clk); cmd_valid = 1; cmd_idx = 5'd5; cmd_slot = 10'd7;
        @(negedge clk); cmd_idx = 5'd2; cmd_slot = 10'd9;
        @(negedge clk); cmd_valid = 0;
        chk("R10 second lookup", 64'(pipe_id), 64'd2);
        @(negedge clk); dir_rsp_valid = 1; dir_rsp_id = 5'd5; dir_rsp_hit = 0;
        @(negedge clk); dir_rsp_id = 5'd2;
        @(negedge clk); dir_rsp_valid = 0;
        cmd_valid = 1; cmd_idx = 5'd5; cmd_slot = 10'd3;
        chk("R10 lowest message first", 64'(msg_id), 64'd2);
        @(negedge clk); cmd_valid = 0;
        chk("R9 busy command no lookup", 64'(pipe_req), 64'd0);
        chk("R10 message held", 64'(msg_id), 64'd2);
        msg_ready = 1;
        @(negedge clk);
        chk("R10 next message", 64'(msg_id), 64'd5);
        chk("R9 slot unchanged", 64'(msg_slot), 64'd7);
        @(negedge clk);
        chk("R9 no extra message", 64'(msg_valid), 64'd0);
        chk("R9 no extra lookup", 64'(pipe_req), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule